// File: doc/BRIEF.md
# Quadratic Sine Synthesizer

This block is a direct digital frequency synthesizer. It adds a 32-bit tuning word to a phase accumulator on every enabled clock. The top sixteen accumulator bits become a phase word. A pipelined converter turns that phase word into a signed 16-bit sine sample without any lookup memory.

The converter folds the phase into one quarter wave. It splits the quarter wave into sixteen equal segments and evaluates a quadratic in the offset inside the selected segment. The coefficients for each segment are constants, fixed when the design is elaborated and selected by the segment number. The polynomial is not evaluated in one piece. The linear and square terms are formed in separate stages and then summed. The output frequency is `f_clk * ftw / 2^32`, which at 147 MHz gives steps of about 0.03 Hz.

The enable input gates the whole block. When it is high, the accumulator advances and every pipeline stage moves forward. When it is low, everything holds.

Top module: `qdds_top`

## Requirements
- R1: Each clock edge with `en` high adds `ftw` to the 32-bit accumulator modulo 2^32; bits 31..16 of the accumulator form the phase word p.
- R2: For phase word p, the output sample is within 2 LSB of 32767·sin(2π·(p+0.5)/65536).
- R3: The accumulator value present at an enabled edge is captured by the converter at that edge. Its sample appears at the output right after the 7th following enabled edge, which is 8 enabled edges counting the capture edge.
- R4: `sampleValid` is low after reset and rises right after the 8th enabled edge. It then stays high until the next reset.
- R5: While `en` is low, the accumulator, the pipeline, `sampleOut` and `sampleValid` hold their values. A new `ftw` applied during that time has no effect.
- R6: A synchronous reset clears the accumulator to zero, `sampleOut` to 0 and `sampleValid` to 0.
- R7: Phase bit 15 selects a negative sample, and phase bit 14 mirrors the lower 14 bits by ones' complement. As a result, phase 0x7FFF gives exactly the sample of phase 0x0000, and phase 0x8000 gives exactly its negative.
- R8: The output never takes the code -32768; its magnitude never exceeds 32767.
- R9: A new `ftw` takes effect at the next enabled edge, and the accumulator keeps its current value across the change, so phase stays continuous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample enable; advances accumulator and pipeline |
| ftw | input | 32 | Frequency tuning word |
| sampleOut | output | 16 | Two's-complement sine sample |
| sampleValid | output | 1 | High once the pipeline holds real samples |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, a 16-bit phase word, sixteen segments and 16-bit samples. These settings make the bench's real-valued sine model exact to the bit in its phase bookkeeping. They also put the quadrant corners 0x0000, 0x4000, 0x7FFF, 0x8000 and 0xC000 within reach of simple tuning words. One continuous run switches the tuning word several times and inserts enable gaps, which shows both the phase continuity and the hold behaviour. Short runs from reset then pin the eight-edge latency, the mirror and sign symmetry, and the absence of the most negative code.

// File: rtl/qdds_pkg.sv
package qdds_pkg;

  localparam int PIPE_DEPTH = 8;
  localparam real QD_PI = 3.14159265358979323846;

  typedef struct packed {
    logic step;
    logic primed;
  } qddsCtl_t;

  function automatic int roundToInt(real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
  endfunction

  // Sample of the quarter wave at segment seg plus fraction t, half-step offset.
  function automatic real quarterSine(int seg, real t, int segBits, int xBits, real amp);
    real pos;
    pos = (real'(seg) + t) * (2.0 ** xBits) + 0.5;
    return amp * $sin(pos * QD_PI / (2.0 ** (segBits + xBits + 1)));
  endfunction

  // which: 0 = constant, 1 = linear, 2 = square coefficient, scaled by 2^frac.
  function automatic int segCoef(int seg, int which, int segBits, int xBits, int frac, real amp);
    real y0, ym, y1, v;
    y0 = quarterSine(seg, 0.0, segBits, xBits, amp);
    ym = quarterSine(seg, 0.5, segBits, xBits, amp);
    y1 = quarterSine(seg, 1.0, segBits, xBits, amp);
    if (which == 0)      v = y0;
    else if (which == 1) v = 4.0 * ym - 3.0 * y0 - y1;
    else                 v = 2.0 * y0 + 2.0 * y1 - 4.0 * ym;
    return roundToInt(v * (2.0 ** frac));
  endfunction

endpackage

// File: rtl/qdds_control.sv
module qdds_control
  import qdds_pkg::*;
#(
  parameter int LAT = PIPE_DEPTH
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  output qddsCtl_t ctl,
  output logic     valid
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0] fillCnt;
  logic             fullNow;

  assign fullNow = (fillCnt == CNT_W'(LAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
    end else if (en && !fullNow) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  assign ctl.step   = en;
  assign ctl.primed = fullNow;
  assign valid      = fullNow;

endmodule

// File: rtl/qdds_datapath.sv
module qdds_datapath
  import qdds_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int PHASE_W  = 16,
  parameter int SEG_BITS = 4,
  parameter int OUT_W    = 16,
  parameter int FRAC     = 8,
  parameter int COEF_W   = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  qddsCtl_t                ctl,
  input  logic [ACC_W-1:0]        ftw,
  output logic signed [OUT_W-1:0] sampleOut
);
  localparam int  X_W     = PHASE_W - 2 - SEG_BITS;
  localparam int  FOLD_W  = PHASE_W - 2;
  localparam int  SEGS    = 1 << SEG_BITS;
  localparam int  SQ_W    = 2 * X_W;
  localparam int  SUM_W   = COEF_W + SQ_W + 2;
  localparam int  SHIFT   = SQ_W + FRAC;
  localparam int  AMP_MAX = (1 << (OUT_W - 1)) - 1;
  localparam real AMP_R   = real'(AMP_MAX);
  localparam logic signed [SUM_W-1:0] RND     = SUM_W'(64'sd1 <<< (SHIFT - 1));
  localparam logic signed [SUM_W-1:0] AMP_LIM = SUM_W'(AMP_MAX);

  // Per-segment constants, built at elaboration and picked by segment index.
  logic signed [COEF_W-1:0] tabA [SEGS];
  logic signed [COEF_W-1:0] tabB [SEGS];
  logic signed [COEF_W-1:0] tabC [SEGS];

  for (genvar k = 0; k < SEGS; k++) begin : gSeg
    localparam int CK_C = segCoef(k, 0, SEG_BITS, X_W, FRAC, AMP_R);
    localparam int CK_B = segCoef(k, 1, SEG_BITS, X_W, FRAC, AMP_R);
    localparam int CK_A = segCoef(k, 2, SEG_BITS, X_W, FRAC, AMP_R);
    assign tabC[k] = COEF_W'(CK_C);
    assign tabB[k] = COEF_W'(CK_B);
    assign tabA[k] = COEF_W'(CK_A);
  end

  // Phase accumulator
  logic [ACC_W-1:0]   accR;
  logic [PHASE_W-1:0] phaseWord;
  logic [FOLD_W-1:0]  foldedPh;

  assign phaseWord = accR[ACC_W-1 -: PHASE_W];
  assign foldedPh  = phaseWord[PHASE_W-2] ? ~phaseWord[FOLD_W-1:0] : phaseWord[FOLD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)           accR <= '0;
    else if (ctl.step) accR <= accR + ftw;
  end

  // Stage 1: fold into the quarter wave
  logic                signR1;
  logic [SEG_BITS-1:0] segR1;
  logic [X_W-1:0]      xR1;

  always_ff @(posedge clk) begin
    if (rst) begin
      signR1 <= 1'b0;
      segR1  <= '0;
      xR1    <= '0;
    end else if (ctl.step) begin
      signR1 <= phaseWord[PHASE_W-1];
      segR1  <= foldedPh[FOLD_W-1 -: SEG_BITS];
      xR1    <= foldedPh[X_W-1:0];
    end
  end

  // Stage 2: coefficient select
  logic                     signR2;
  logic [X_W-1:0]           xR2;
  logic signed [COEF_W-1:0] aR2, bR2, cR2;

  always_ff @(posedge clk) begin
    if (rst) begin
      signR2 <= 1'b0;
      xR2    <= '0;
      aR2    <= '0;
      bR2    <= '0;
      cR2    <= '0;
    end else if (ctl.step) begin
      signR2 <= signR1;
      xR2    <= xR1;
      aR2    <= tabA[segR1];
      bR2    <= tabB[segR1];
      cR2    <= tabC[segR1];
    end
  end

  // Stage 3: square of offset and linear partial term
  logic                     signR3;
  logic [SQ_W-1:0]          xSqR3;
  logic signed [SUM_W-1:0]  bxR3;
  logic signed [COEF_W-1:0] aR3, cR3;

  always_ff @(posedge clk) begin
    if (rst) begin
      signR3 <= 1'b0;
      xSqR3  <= '0;
      bxR3   <= '0;
      aR3    <= '0;
      cR3    <= '0;
    end else if (ctl.step) begin
      signR3 <= signR2;
      xSqR3  <= SQ_W'(xR2) * SQ_W'(xR2);
      bxR3   <= SUM_W'(bR2) * SUM_W'($signed({1'b0, xR2}));
      aR3    <= aR2;
      cR3    <= cR2;
    end
  end

  // Stage 4: square partial term, aligned constant plus linear term
  logic                    signR4;
  logic signed [SUM_W-1:0] axxR4, partR4;

  always_ff @(posedge clk) begin
    if (rst) begin
      signR4 <= 1'b0;
      axxR4  <= '0;
      partR4 <= '0;
    end else if (ctl.step) begin
      signR4 <= signR3;
      axxR4  <= SUM_W'(aR3) * SUM_W'($signed({1'b0, xSqR3}));
      partR4 <= (SUM_W'(cR3) <<< SQ_W) + (bxR3 <<< X_W);
    end
  end

  // Stage 5: sum of partial terms
  logic                    signR5;
  logic signed [SUM_W-1:0] sumR5;

  always_ff @(posedge clk) begin
    if (rst) begin
      signR5 <= 1'b0;
      sumR5  <= '0;
    end else if (ctl.step) begin
      signR5 <= signR4;
      sumR5  <= partR4 + axxR4;
    end
  end

  // Stage 6: round and scale
  logic                    signR6;
  logic signed [SUM_W-1:0] magR6;

  always_ff @(posedge clk) begin
    if (rst) begin
      signR6 <= 1'b0;
      magR6  <= '0;
    end else if (ctl.step) begin
      signR6 <= signR5;
      magR6  <= (sumR5 + RND) >>> SHIFT;
    end
  end

  // Stage 7: saturate magnitude
  logic             signR7;
  logic [OUT_W-1:0] satR7;

  always_ff @(posedge clk) begin
    if (rst) begin
      signR7 <= 1'b0;
      satR7  <= '0;
    end else if (ctl.step) begin
      signR7 <= signR6;
      if (magR6 > AMP_LIM)               satR7 <= OUT_W'(AMP_MAX);
      else if (magR6 < $signed(SUM_W'(0))) satR7 <= '0;
      else                               satR7 <= magR6[OUT_W-1:0];
    end
  end

  // Stage 8: apply half-cycle sign
  always_ff @(posedge clk) begin
    if (rst)           sampleOut <= '0;
    else if (ctl.step) sampleOut <= signR7 ? $signed(-satR7) : $signed(satR7);
  end

endmodule

// File: rtl/qdds_top.sv
module qdds_top
  import qdds_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int PHASE_W  = 16,
  parameter int SEG_BITS = 4,
  parameter int OUT_W    = 16,
  parameter int FRAC     = 8,
  parameter int COEF_W   = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        ftw,
  output logic signed [OUT_W-1:0] sampleOut,
  output logic                    sampleValid
);
  qddsCtl_t ctl;

  qdds_control #(
    .LAT(PIPE_DEPTH)
  ) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .ctl  (ctl),
    .valid(sampleValid)
  );

  qdds_datapath #(
    .ACC_W   (ACC_W),
    .PHASE_W (PHASE_W),
    .SEG_BITS(SEG_BITS),
    .OUT_W   (OUT_W),
    .FRAC    (FRAC),
    .COEF_W  (COEF_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .ftw      (ftw),
    .sampleOut(sampleOut)
  );

endmodule

// File: rtl/qdds_checker.sv
module qdds_checker #(
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic signed [OUT_W-1:0] sampleOut,
  input logic                    sampleValid
);
  localparam logic signed [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!sampleValid && sampleOut == '0)); // R6

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(sampleOut) && $stable(sampleValid))); // R5

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> sampleValid); // R4

  AST_VALID_RISE_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    $rose(sampleValid) |-> $past(en)); // R3

  AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (rst)
    sampleOut != MIN_CODE); // R8

endmodule

bind qdds_top qdds_checker #(.OUT_W(OUT_W)) u_qddsChk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .sampleOut  (sampleOut),
  .sampleValid(sampleValid)
);

// File: tb/qdds_top_bench.sv
module qdds_top_bench;
  localparam int  CLK_PERIOD = 10;
  localparam int  PIPE       = 8;
  localparam real TOL        = 2.0;
  localparam real AMP        = 32767.0;
  localparam real PI_R       = 3.14159265358979323846;

  localparam int ROWS = 6;
  localparam logic [31:0] ROW_FTW [ROWS] = '{32'h0123_4567, 32'h0800_0000, 32'hFFFF_FFFF,
                                             32'h4000_0001, 32'hF000_0000, 32'h0000_1000};
  localparam int ROW_LEN [ROWS] = '{40, 30, 20, 20, 25, 10};
  localparam bit ROW_GAP [ROWS] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               en  = 1'b0;
  logic [31:0]        ftw = '0;
  logic signed [15:0] sampleOut;
  logic               sampleValid;

  int          checks   = 0;
  int          failures = 0;
  bit          finished = 1'b0;
  logic [31:0] accModel = '0;
  logic [15:0] ring [8];
  int          enCount  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdds_top u_qdds_top (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .ftw        (ftw),
    .sampleOut  (sampleOut),
    .sampleValid(sampleValid)
  );

  function automatic real expectFor(logic [15:0] p);
    return AMP * $sin(2.0 * PI_R * (real'(p) + 0.5) / 65536.0);
  endfunction

  task automatic checkInt(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkNear(string req, string what, int act, real exp);
    real d;
    checks++;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    if (d > TOL) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%f", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    en  = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    accModel = '0;
    enCount  = 0;
  endtask

  task automatic step(bit e, logic [31:0] w);
    en  = e;
    ftw = w;
    @(posedge clk);
    if (e) begin
      ring[enCount % 8] = accModel[31:16];
      accModel = accModel + w;
      enCount++;
    end
    @(negedge clk);
  endtask

  task automatic checkOut(string req);
    checkInt(req, "valid", int'(sampleValid), (enCount >= PIPE) ? 1 : 0);
    if (enCount >= PIPE)
      checkNear(req, "sample", int'(sampleOut), expectFor(ring[(enCount - PIPE) % 8]));
  endtask

  initial begin
    int s0;
    int s1;
    @(negedge clk);
    doReset();
    // R6: reset state
    checkInt("R6", "reset sample", int'(sampleOut), 0);
    checkInt("R6", "reset valid", int'(sampleValid), 0);

    // Table walk: tuning changes without reset (R1, R9), gaps (R5)
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < ROW_LEN[r]; c++) begin
        bit e;
        int prevOut;
        int prevValid;
        e = ROW_GAP[r] ? (c % 3 != 2) : 1'b1;
        prevOut   = int'(sampleOut);
        prevValid = int'(sampleValid);
        step(e, ROW_FTW[r]);
        if (!e) begin
          checkInt("R5", "held sample", int'(sampleOut), prevOut);
          checkInt("R5", "held valid", int'(sampleValid), prevValid);
        end
        checkOut("R1 R2 R4 R9");
      end
    end

    // R5: a tuning word applied while stalled is ignored
    for (int c = 0; c < 3; c++) step(1'b0, 32'h1357_9BDF);
    for (int c = 0; c < 10; c++) begin
      step(1'b1, 32'h0200_0000);
      checkOut("R5 R9");
    end

    // R3, R4: exact latency from reset
    doReset();
    for (int c = 0; c < 7; c++) step(1'b1, 32'h1000_0000);
    checkInt("R4", "valid before 8th edge", int'(sampleValid), 0);
    step(1'b1, 32'h1000_0000);
    checkInt("R3", "valid at 8th edge", int'(sampleValid), 1);
    checkNear("R3", "first sample phase 0", int'(sampleOut), expectFor(16'h0000));
    step(1'b1, 32'h1000_0000);
    checkNear("R3", "second sample", int'(sampleOut), expectFor(16'h1000));

    // R7: mirror pair 0x0000 / 0x7FFF
    doReset();
    for (int c = 0; c < 8; c++) step(1'b1, 32'h7FFF_0000);
    s0 = int'(sampleOut);
    step(1'b1, 32'h7FFF_0000);
    s1 = int'(sampleOut);
    checkInt("R7", "mirror 0x7FFF", s1, s0);

    // R7: sign pair 0x0000 / 0x8000
    doReset();
    for (int c = 0; c < 8; c++) step(1'b1, 32'h8000_0000);
    s0 = int'(sampleOut);
    step(1'b1, 32'h8000_0000);
    s1 = int'(sampleOut);
    checkInt("R7", "negated 0x8000", s1, -s0);

    // R8: quarter steps reach the negative peak
    doReset();
    for (int c = 0; c < 12; c++) begin
      step(1'b1, 32'h4000_0000);
      if (enCount >= PIPE) begin
        checkInt("R8", "no min code", (sampleOut == 16'sh8000) ? 1 : 0, 0);
        checkNear("R8", "quadrant corner", int'(sampleOut), expectFor(ring[(enCount - PIPE) % 8]));
      end
    end

    // R6: reset in the middle of a run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkInt("R6", "mid-run reset sample", int'(sampleOut), 0);
    checkInt("R6", "mid-run reset valid", int'(sampleValid), 0);
    rst = 1'b0;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL R4 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule